// File: doc/BRIEF.md
# Differential Quadrature Encoder Counter Bank

This block turns the signals of several incremental encoders into signed position counts. Each channel receives its A and B phases as complementary line pairs. Every line passes through a two-flop synchroniser. The channel then decodes in 4x mode, so each edge on A or on B moves the count by one step. The count goes up or down by one depending on the direction of rotation and wraps at the counter width.

The block also checks each line pair. When the two lines of a pair are not complementary, the count holds for that cycle and a sticky per-channel pair fault is set. When A and B both toggle in the same cycle, the step is illegal: the count holds and a separate sticky sequence fault is set. A single clear input resets both kinds of fault on every channel.

A write strobe loads an enable mask with one bit per channel. A disabled channel freezes its count and its faults. The counts and fault bits are exposed directly as outputs, with no bus wrapper. The block has no data stream, so all pins are plain level control and status signals with no valid/ready handshake.

Top module: `quad_enc_bank`

## Requirements
- R1: After reset every count is 0, every pair fault and sequence fault is 0, and every channel is enabled (enable mask all ones).
- R2: A level change on an input pin sampled at rising edge k appears in the count after rising edge k+2 and not earlier.
- R3: With (A,B) moving through the order 00, 10, 11, 01, 00, each single-phase change raises that channel's count by exactly one.
- R4: Moving through the same order in reverse (00, 01, 11, 10, 00) lowers the count by exactly one per change.
- R5: Counts are CNT_W bits (16 by default) and wrap modulo 2^CNT_W in both directions. Channel i occupies count bits [CNT_W*i+CNT_W-1 : CNT_W*i], with bits [7:0] of that slice as the low byte and [15:8] as the high byte.
- R6: When both A and B change in the same synchronised cycle on an enabled channel, the count does not change and seq_fault for that channel becomes 1 and stays 1.
- R7: When, on an enabled channel, a_p equals a_n or b_p equals b_n in a synchronised cycle, the count does not change in that cycle and pair_fault for that channel becomes 1 and stays 1.
- R8: A cycle with fault_clr high clears both sticky faults on all channels, except that a fault detected in the same cycle sets its bit anyway.
- R9: On an edge with en_wr high, bit i of en_wdata becomes the enable of channel i, visible on chan_en after that edge; otherwise chan_en holds.
- R10: A disabled channel keeps its count and faults unchanged whatever its inputs do. Edges that occur while it is disabled are not counted once it is enabled again.
- R11: Channels are independent: activity or faults on one channel never alter another channel's count or faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_p | input | NUM_CH | Positive line of phase A, one bit per channel |
| enc_a_n | input | NUM_CH | Negative line of phase A |
| enc_b_p | input | NUM_CH | Positive line of phase B |
| enc_b_n | input | NUM_CH | Negative line of phase B |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | NUM_CH | New enable mask |
| fault_clr | input | 1 | Clears all sticky faults |
| chan_en | output | NUM_CH | Current enable mask |
| count | output | NUM_CH*CNT_W | Packed position counts, channel 0 in the lowest slice |
| pair_fault | output | NUM_CH | Sticky non-complementary pair fault per channel |
| seq_fault | output | NUM_CH | Sticky both-phases-changed fault per channel |

## Verification
The bench builds the block with its defaults: four channels and 16-bit counts. Four channels are enough to show that faults, enables and steps stay within their own channel while the other three run. The 16-bit width lets the wrap in both directions be reached within a few steps across zero, and lets the high byte be observed at 0xFF. A behavioural model with a three-deep history of sampled pins is compared with every output on every cycle, so the two-cycle synchroniser latency is checked along with the values.

// File: rtl/qe_pkg.sv
package qe_pkg;
  typedef struct packed {
    logic a;
    logic b;
  } qe_ab_t;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } qe_step_e;
endpackage

// File: rtl/qe_sync.sv
module qe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else        stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/qe_en_reg.sv
module qe_en_reg #(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] EN_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= EN_RESET;
    else if (wr) en <= wdata;
  end

  // R9: a write lands on the mask one edge later
  a_r9_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en == $past(wdata)));
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en));
endmodule

// File: rtl/qe_channel.sv
module qe_channel
  import qe_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             a_p,
  input  logic             a_n,
  input  logic             b_p,
  input  logic             b_n,
  output logic [CNT_W-1:0] cnt,
  output logic             pair_fault,
  output logic             seq_fault
);
  qe_ab_t   prev_q;
  qe_step_e step;
  logic     pair_err;
  logic     a_chg, b_chg;
  logic     set_pair, set_seq;

  assign pair_err = (a_p ~^ a_n) | (b_p ~^ b_n);
  assign a_chg    = a_p ^ prev_q.a;
  assign b_chg    = b_p ^ prev_q.b;

  always_comb begin
    if (!a_chg && !b_chg)      step = STEP_NONE;
    else if (a_chg && b_chg)   step = STEP_BAD;
    else if (a_p ^ prev_q.b)   step = STEP_UP;
    else                       step = STEP_DN;
  end

  assign set_pair = en && pair_err;
  assign set_seq  = en && !pair_err && (step == STEP_BAD);

  // previous phase state follows the inputs even while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= '{a: a_p, b: b_p};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en && !pair_err) begin
      case (step)
        STEP_UP: cnt <= cnt + CNT_W'(1);
        STEP_DN: cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_fault <= 1'b0;
      seq_fault  <= 1'b0;
    end else begin
      pair_fault <= set_pair | (pair_fault & ~clr);
      seq_fault  <= set_seq  | (seq_fault  & ~clr);
    end
  end

  // R10: disabled channel keeps its count and faults
  a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && (clr || ($stable(pair_fault) && $stable(seq_fault)))));
  // R7: a broken pair freezes the count and raises the fault
  a_r7_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pair_err) |=> ($stable(cnt) && pair_fault));
  // R6: both phases changing freezes the count and raises the fault
  a_r6_double_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pair_err && a_chg && b_chg) |=> ($stable(cnt) && seq_fault));
  // R8: clear without a new fault empties both sticky bits
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pair_err && !(a_chg && b_chg)) |=> (!pair_fault && !seq_fault));
  // R3: the count never moves by more than one per cycle
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))
              || (cnt == $past(cnt) - CNT_W'(1))));
endmodule

// File: rtl/quad_enc_bank.sv
module quad_enc_bank #(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_CH-1:0] EN_RESET = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       enc_a_p,
  input  logic [NUM_CH-1:0]       enc_a_n,
  input  logic [NUM_CH-1:0]       enc_b_p,
  input  logic [NUM_CH-1:0]       enc_b_n,
  input  logic                    en_wr,
  input  logic [NUM_CH-1:0]       en_wdata,
  input  logic                    fault_clr,
  output logic [NUM_CH-1:0]       chan_en,
  output logic [NUM_CH*CNT_W-1:0] count,
  output logic [NUM_CH-1:0]       pair_fault,
  output logic [NUM_CH-1:0]       seq_fault
);
  localparam int SW = 4 * NUM_CH;
  // idle lines: positive low, negative high, so the pairs start valid
  localparam logic [SW-1:0] SYNC_RST = {{NUM_CH{1'b1}}, {NUM_CH{1'b0}},
                                        {NUM_CH{1'b1}}, {NUM_CH{1'b0}}};

  logic [SW-1:0]     raw, synced;
  logic [NUM_CH-1:0] s_a_p, s_a_n, s_b_p, s_b_n;

  assign raw = {enc_b_n, enc_b_p, enc_a_n, enc_a_p};

  qe_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign {s_b_n, s_b_p, s_a_n, s_a_p} = synced;

  qe_en_reg #(.NUM_CH(NUM_CH), .EN_RESET(EN_RESET)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata), .en(chan_en)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    qe_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (chan_en[i]),
      .clr       (fault_clr),
      .a_p       (s_a_p[i]),
      .a_n       (s_a_n[i]),
      .b_p       (s_b_p[i]),
      .b_n       (s_b_n[i]),
      .cnt       (count[CNT_W*i +: CNT_W]),
      .pair_fault(pair_fault[i]),
      .seq_fault (seq_fault[i])
    );
  end
endmodule

// File: tb/quad_enc_bank_bench.sv
`timescale 1ns/1ps
module quad_enc_bank_bench;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ap = '0, an = '1, bp = '0, bn = '1;
  logic en_wr = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic fault_clr = 1'b0;
  logic [N-1:0] chan_en, pair_fault, seq_fault;
  logic [N*W-1:0] count;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int st [N];

  always #2 clk = ~clk;

  quad_enc_bank u_quad_enc_bank (
    .clk(clk), .rst_n(rst_n),
    .enc_a_p(ap), .enc_a_n(an), .enc_b_p(bp), .enc_b_n(bn),
    .en_wr(en_wr), .en_wdata(en_wdata), .fault_clr(fault_clr),
    .chan_en(chan_en), .count(count),
    .pair_fault(pair_fault), .seq_fault(seq_fault)
  );

  // ---------------- reference model ----------------
  logic [4*N-1:0] h0, h1, h2;
  int unsigned m_cnt [N];
  logic [N-1:0] m_en, m_pf, m_sf;

  function automatic int pos_of(logic a, logic b);
    if (!a && !b) return 0;
    if (a && !b)  return 1;
    if (a && b)   return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = {{N{1'b1}}, {N{1'b0}}, {N{1'b1}}, {N{1'b0}}};
      h1 = h0; h2 = {4*N{1'b0}};
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
      m_en = '1; m_pf = '0; m_sf = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic cap, can, cbp, cbn, pa, pb, bad;
        int d;
        cap = h1[i]; can = h1[N+i]; cbp = h1[2*N+i]; cbn = h1[3*N+i];
        pa = h2[i]; pb = h2[2*N+i];
        bad = (cap == can) || (cbp == cbn);
        d = (pos_of(cap, cbp) - pos_of(pa, pb) + 4) % 4;
        if (fault_clr) begin m_pf[i] = 1'b0; m_sf[i] = 1'b0; end
        if (m_en[i]) begin
          if (bad) m_pf[i] = 1'b1;
          else if (d == 2) m_sf[i] = 1'b1;
          else if (d == 1) m_cnt[i] = (m_cnt[i] + 1) % 65536;
          else if (d == 3) m_cnt[i] = (m_cnt[i] + 65535) % 65536;
        end
      end
      if (en_wr) m_en = en_wdata;
      h2 = h1; h1 = h0; h0 = {bn, bp, an, ap};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        checks++;
        if (count[W*i +: W] != m_cnt[i][W-1:0] || pair_fault[i] != m_pf[i]
            || seq_fault[i] != m_sf[i] || chan_en[i] != m_en[i]) begin
          errors++;
          $display("FAIL %s R11 ch%0d cnt=%h pf=%b sf=%b en=%b exp cnt=%h pf=%b sf=%b en=%b",
                   cur_req, i, count[W*i +: W], pair_fault[i], seq_fault[i], chan_en[i],
                   m_cnt[i][W-1:0], m_pf[i], m_sf[i], m_en[i]);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic put(int ch, int s);
    st[ch] = s;
    ap[ch] = (s == 1) || (s == 2);
    bp[ch] = (s == 2) || (s == 3);
    an[ch] = ~ap[ch];
    bn[ch] = ~bp[ch];
  endtask

  task automatic move(int ch, int delta, int n);
    for (int k = 0; k < n; k++) begin
      put(ch, (st[ch] + delta + 4) % 4);
      cyc(2);
    end
    cyc(3);
  endtask

  function automatic logic [W-1:0] cnt_of(int ch);
    return count[W*ch +: W];
  endfunction

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) st[i] = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1", cnt_of(0), 16'h0);
    chk("R1", {12'h0, chan_en}, 16'h000F);
    chk("R1", {8'h0, pair_fault, seq_fault}, 16'h0);

    // R3 up counting on ch0
    cur_req = "R3";
    move(0, 1, 5);
    chk("R3", cnt_of(0), 16'd5);

    // R2 latency on ch3
    cur_req = "R2";
    put(3, 1);
    cyc(2);
    chk("R2", cnt_of(3), 16'd0);
    cyc(1);
    chk("R2", cnt_of(3), 16'd1);
    cyc(3);

    // R4 / R5 down across zero and back on ch1
    cur_req = "R4";
    move(1, -1, 3);
    chk("R4", cnt_of(1), 16'hFFFD);
    chk("R5", {8'h0, count[W+8 +: 8]}, 16'h00FF);
    cur_req = "R5";
    move(1, 1, 3);
    chk("R5", cnt_of(1), 16'h0000);

    // R6 double change on ch2
    cur_req = "R6";
    put(2, 2);
    cyc(5);
    chk("R6", cnt_of(2), 16'd0);
    chk("R6", {15'h0, seq_fault[2]}, 16'd1);
    chk("R11", {15'h0, seq_fault[0]}, 16'd0);

    // R7 broken pair on ch3
    cur_req = "R7";
    an[3] = ap[3];
    cyc(2);
    an[3] = ~ap[3];
    cyc(4);
    chk("R7", {15'h0, pair_fault[3]}, 16'd1);
    chk("R7", cnt_of(3), 16'd1);

    // R8 clear
    cur_req = "R8";
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0; cyc(1);
    chk("R8", {8'h0, pair_fault, seq_fault}, 16'h0);
    // fault arriving while clear is high still sets
    bn[0] = bp[0];
    cyc(3);
    fault_clr = 1'b1; cyc(2); fault_clr = 1'b0;
    chk("R8", {15'h0, pair_fault[0]}, 16'd1);
    bn[0] = ~bp[0];
    cyc(4);
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0; cyc(1);
    chk("R8", {15'h0, pair_fault[0]}, 16'd0);

    // R9 / R10 disable ch0 and ch2
    cur_req = "R9";
    en_wr = 1'b1; en_wdata = 4'b1010; cyc(1); en_wr = 1'b0;
    chk("R9", {12'h0, chan_en}, 16'h000A);
    cur_req = "R10";
    move(0, 1, 4);
    an[0] = ap[0]; cyc(3); an[0] = ~ap[0]; cyc(3);
    chk("R10", cnt_of(0), 16'd5);
    chk("R10", {15'h0, pair_fault[0]}, 16'd0);
    en_wr = 1'b1; en_wdata = 4'b1111; cyc(1); en_wr = 1'b0;
    cyc(3);
    chk("R10", cnt_of(0), 16'd5);
    move(0, 1, 1);
    chk("R10", cnt_of(0), 16'd6);

    // R11 a mixed burst on several channels
    cur_req = "R11";
    for (int k = 0; k < 20; k++) begin
      put(0, (st[0] + 1) % 4);
      put(1, (st[1] + 3) % 4);
      if (k % 3 == 0) put(2, (st[2] + 1) % 4);
      cyc(1);
    end
    cyc(5);
    chk("R11", cnt_of(3), 16'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule